// File: doc/BRIEF.md
# Per-Port Egress Decision Filter

This block sits after the address lookup of a small Ethernet switch. It turns the raw lookup answer into the final forwarding decision for each frame. The raw answer holds the ingress port, the destination port mask, a broadcast/multicast flag and the port chosen as sniffer. Each port has one 8-bit forwarding-control register. These registers enable loopback, receive and transmit mirroring, exclusion of broadcast/multicast frames from the receive mirror, and gating of receive, transmit and source-address learning. The block combines all of these into one egress mask, a drop flag and a learn-enable flag.

The block also holds the register file. Software can write and read the control registers through a simple port/select/data interface. The same interface returns a read-only status word per port, built from the live link, duplex, speed, self-test and flow-control inputs.

Sequencing uses a two-state machine. `ST_IDLE` means no decision is being presented. `ST_EMIT` means a registered decision is on the outputs for one cycle. The transitions are:
- `ST_IDLE -> ST_EMIT` on an accepted lookup (`lk_valid` with `lk_ready`).
- `ST_EMIT -> ST_EMIT` on a back-to-back accept.
- `ST_EMIT -> ST_IDLE` when no lookup is accepted.

`lk_ready` is held high, so a lookup is accepted in any cycle it is offered.

Top module: `fwd_filter_top`

## Requirements
- R1: After reset every control register reads 0, `dec_valid` is 0 and `lk_ready` is 1.
- R2: A write with `reg_sel`=0 stores all 8 bits of `reg_wdata` into the control register of `reg_port`. From the next cycle it reads back unchanged. Control bit layout: bit7 loopback, bit6 transmit-mirror, bit5 receive-mirror, bit4 skip broadcast/multicast in receive-mirror, bit3 spare, bit2 transmit-off, bit1 receive-off, bit0 learn-off.
- R3: A read with `reg_sel`=1 returns the port's status word. Bit0 is link up, bit1 is full duplex, bit2 is 100 Mb/s, bit4 is self-test failure and bit5 is partner flow control. Bits 3, 6 and 7 read 0. Writes with `reg_sel`=1 change no register.
- R4: An accepted lookup raises `dec_valid` for exactly the following cycle, with the decision on the outputs. No accept means no `dec_valid`.
- R5: Without loopback on the ingress port, the ingress port is cleared from the destination mask. With loopback (bit7) set, the ingress port is added to it.
- R6: Receive-mirror (bit5) on the ingress port adds the sniffer port to the mask.
- R7: With bit4 also set on the ingress port, the receive-mirror copy is skipped for frames flagged broadcast/multicast. Other frames are still mirrored.
- R8: When any port in the forwarded set has transmit-mirror (bit6) set, the sniffer port is added.
- R9: A port with transmit-off (bit2) never appears in the final mask, whether as destination, loopback target or sniffer. Such a port also does not trigger transmit-mirror.
- R10: Receive-off (bit1) on the ingress port sets `dec_drop`=1, clears the mask and clears `dec_learn`, overriding every other control.
- R11: `dec_learn` is 1 unless the ingress port has learn-off (bit0) or receive-off set.
- R12: A sniffer port number at or above the port count adds no mirror copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup result offered |
| lk_ready | output | 1 | Lookup result accepted (always 1 after reset) |
| lk_ingress | input | PW | Ingress port number |
| lk_dest | input | NPORTS | Raw destination mask from lookup |
| lk_bcast | input | 1 | Destination is broadcast or multicast |
| sniffer_port | input | PW | Port receiving mirror copies |
| dec_valid | output | 1 | Decision present |
| dec_mask | output | NPORTS | Final egress mask |
| dec_drop | output | 1 | Frame discarded |
| dec_learn | output | 1 | Source address may be learned |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_port | input | PW | Register port index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| st_link | input | NPORTS | Per-port link up |
| st_duplex | input | NPORTS | Per-port full duplex |
| st_speed | input | NPORTS | Per-port 100 Mb/s |
| st_bist_fail | input | NPORTS | Per-port self-test failure |
| st_partner_fc | input | NPORTS | Per-port partner flow control enabled |

## Verification
The assertions assume that `lk_ingress` and the register `reg_port` used for writes name an existing port. They also assume that the inputs stay at known values while reset is released. The transmit-off check compares the emitted mask against the control values sampled in the accepting cycle. It therefore assumes that software writes landing in that cycle are not meant to affect the decision already in flight. The bench drives only existing ingress ports and performs register writes only between lookups. It offers an out-of-range value on `sniffer_port` alone, where R12 defines the behaviour.

// File: rtl/fwd_filter_pkg.sv
package fwd_filter_pkg;

    // Bit positions inside a control register (decoded by fwd_regfile)
    localparam int CB_LOOP    = 7;
    localparam int CB_MIR_TX  = 6;
    localparam int CB_MIR_RX  = 5;
    localparam int CB_SKIP_BM = 4;
    localparam int CB_TX_OFF  = 2;
    localparam int CB_RX_OFF  = 1;
    localparam int CB_LRN_OFF = 0;

    // Bit positions inside a status word
    localparam int SB_LINK = 0;
    localparam int SB_FDX  = 1;
    localparam int SB_SPD  = 2;
    localparam int SB_BIST = 4;
    localparam int SB_PFC  = 5;

    localparam int REG_W = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/fwd_regfile.sv
module fwd_regfile
    import fwd_filter_pkg::*;
#(
    parameter int NPORTS = 3,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [PW-1:0]     reg_port,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NPORTS-1:0] st_link,
    input  logic [NPORTS-1:0] st_duplex,
    input  logic [NPORTS-1:0] st_speed,
    input  logic [NPORTS-1:0] st_bist_fail,
    input  logic [NPORTS-1:0] st_partner_fc,
    output logic [NPORTS-1:0] v_loop,
    output logic [NPORTS-1:0] v_mir_tx,
    output logic [NPORTS-1:0] v_mir_rx,
    output logic [NPORTS-1:0] v_skip_bm,
    output logic [NPORTS-1:0] v_tx_off,
    output logic [NPORTS-1:0] v_rx_off,
    output logic [NPORTS-1:0] v_lrn_off
);

    logic [REG_W-1:0] ctrl_q [NPORTS];
    logic [REG_W-1:0] stat_w [NPORTS];
    logic             port_ok;

    assign port_ok = (32'(reg_port) < NPORTS);

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[i] <= '0;
            end else if (reg_we && !reg_sel && (reg_port == PW'(i))) begin
                ctrl_q[i] <= reg_wdata;
            end
        end

        always_comb begin
            stat_w[i]          = '0;
            stat_w[i][SB_LINK] = st_link[i];
            stat_w[i][SB_FDX]  = st_duplex[i];
            stat_w[i][SB_SPD]  = st_speed[i];
            stat_w[i][SB_BIST] = st_bist_fail[i];
            stat_w[i][SB_PFC]  = st_partner_fc[i];
        end

        assign v_loop[i]    = ctrl_q[i][CB_LOOP];
        assign v_mir_tx[i]  = ctrl_q[i][CB_MIR_TX];
        assign v_mir_rx[i]  = ctrl_q[i][CB_MIR_RX];
        assign v_skip_bm[i] = ctrl_q[i][CB_SKIP_BM];
        assign v_tx_off[i]  = ctrl_q[i][CB_TX_OFF];
        assign v_rx_off[i]  = ctrl_q[i][CB_RX_OFF];
        assign v_lrn_off[i] = ctrl_q[i][CB_LRN_OFF];
    end

    always_comb begin
        reg_rdata = '0;
        if (port_ok) begin
            reg_rdata = reg_sel ? stat_w[reg_port] : ctrl_q[reg_port];
        end
    end

    // R3: spare status bits never leak onto the read bus
    p_status_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[7:6] == 2'b00 && reg_rdata[3] == 1'b0));

    // R2: a control write is visible on the following read of that port
    p_ctrl_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_sel && port_ok) |=> (ctrl_q[$past(reg_port)] == $past(reg_wdata)));

endmodule

// File: rtl/fwd_decide.sv
module fwd_decide
    import fwd_filter_pkg::*;
#(
    parameter int NPORTS = 3,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [PW-1:0]     ingress,
    input  logic [NPORTS-1:0] dest,
    input  logic              bcast,
    input  logic [PW-1:0]     sniffer,
    input  logic [NPORTS-1:0] v_loop,
    input  logic [NPORTS-1:0] v_mir_tx,
    input  logic [NPORTS-1:0] v_mir_rx,
    input  logic [NPORTS-1:0] v_skip_bm,
    input  logic [NPORTS-1:0] v_tx_off,
    input  logic [NPORTS-1:0] v_rx_off,
    input  logic [NPORTS-1:0] v_lrn_off,
    output logic [NPORTS-1:0] out_mask,
    output logic              out_drop,
    output logic              out_learn
);

    logic [NPORTS-1:0] ing_oh;
    logic [NPORTS-1:0] snf_oh;
    logic [NPORTS-1:0] base_set;
    logic [NPORTS-1:0] fwd_set;
    logic [NPORTS-1:0] mir_set;
    logic              snf_ok;
    logic              tx_mir_hit;
    logic              rx_mir_hit;
    logic              in_loop, in_mrx, in_skip, in_rxoff, in_lrnoff;

    for (genvar i = 0; i < NPORTS; i++) begin : g_onehot
        assign ing_oh[i] = (ingress == PW'(i));
        assign snf_oh[i] = (sniffer == PW'(i));
    end

    assign snf_ok    = (32'(sniffer) < NPORTS);
    assign in_loop   = |(v_loop    & ing_oh);
    assign in_mrx    = |(v_mir_rx  & ing_oh);
    assign in_skip   = |(v_skip_bm & ing_oh);
    assign in_rxoff  = |(v_rx_off  & ing_oh);
    assign in_lrnoff = |(v_lrn_off & ing_oh);

    always_comb begin
        base_set   = in_loop ? (dest | ing_oh) : (dest & ~ing_oh);
        fwd_set    = base_set & ~v_tx_off;
        tx_mir_hit = |(fwd_set & v_mir_tx);
        rx_mir_hit = in_mrx && !(in_skip && bcast);
        mir_set    = ((tx_mir_hit || rx_mir_hit) && snf_ok) ? snf_oh : '0;
        if (in_rxoff) begin
            out_mask  = '0;
            out_drop  = 1'b1;
            out_learn = 1'b0;
        end else begin
            out_mask  = (fwd_set | mir_set) & ~v_tx_off;
            out_drop  = 1'b0;
            out_learn = !in_lrnoff;
        end
    end

endmodule

// File: rtl/fwd_filter_top.sv
module fwd_filter_top
    import fwd_filter_pkg::*;
#(
    parameter int NPORTS = 3,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [PW-1:0]     lk_ingress,
    input  logic [NPORTS-1:0] lk_dest,
    input  logic              lk_bcast,
    input  logic [PW-1:0]     sniffer_port,
    output logic              dec_valid,
    output logic [NPORTS-1:0] dec_mask,
    output logic              dec_drop,
    output logic              dec_learn,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [PW-1:0]     reg_port,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NPORTS-1:0] st_link,
    input  logic [NPORTS-1:0] st_duplex,
    input  logic [NPORTS-1:0] st_speed,
    input  logic [NPORTS-1:0] st_bist_fail,
    input  logic [NPORTS-1:0] st_partner_fc
);

    logic [NPORTS-1:0] v_loop, v_mir_tx, v_mir_rx, v_skip_bm;
    logic [NPORTS-1:0] v_tx_off, v_rx_off, v_lrn_off;
    logic [NPORTS-1:0] nx_mask;
    logic              nx_drop, nx_learn;
    logic              accept;
    seq_state_e        state_q, state_d;

    fwd_regfile #(.NPORTS(NPORTS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_sel      (reg_sel),
        .reg_port     (reg_port),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .st_link      (st_link),
        .st_duplex    (st_duplex),
        .st_speed     (st_speed),
        .st_bist_fail (st_bist_fail),
        .st_partner_fc(st_partner_fc),
        .v_loop       (v_loop),
        .v_mir_tx     (v_mir_tx),
        .v_mir_rx     (v_mir_rx),
        .v_skip_bm    (v_skip_bm),
        .v_tx_off     (v_tx_off),
        .v_rx_off     (v_rx_off),
        .v_lrn_off    (v_lrn_off)
    );

    fwd_decide #(.NPORTS(NPORTS)) u_decide (
        .ingress  (lk_ingress),
        .dest     (lk_dest),
        .bcast    (lk_bcast),
        .sniffer  (sniffer_port),
        .v_loop   (v_loop),
        .v_mir_tx (v_mir_tx),
        .v_mir_rx (v_mir_rx),
        .v_skip_bm(v_skip_bm),
        .v_tx_off (v_tx_off),
        .v_rx_off (v_rx_off),
        .v_lrn_off(v_lrn_off),
        .out_mask (nx_mask),
        .out_drop (nx_drop),
        .out_learn(nx_learn)
    );

    assign lk_ready = rst_n;
    assign accept   = lk_valid && lk_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)  state_d = ST_EMIT;
            ST_EMIT: if (!accept) state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_mask  <= '0;
            dec_drop  <= 1'b0;
            dec_learn <= 1'b0;
        end else if (accept) begin
            dec_mask  <= nx_mask;
            dec_drop  <= nx_drop;
            dec_learn <= nx_learn;
        end
    end

    assign dec_valid = (state_q == ST_EMIT);

    // R4: every accept yields a decision next cycle
    p_emit_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> dec_valid);

    // R4: no decision without an accept
    p_no_spurious_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !dec_valid);

    // R10: a dropped frame goes nowhere and is not learned
    p_drop_is_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_drop) |-> (dec_mask == '0 && !dec_learn));

    // R9: transmit-off ports never appear in an emitted mask
    p_txoff_excluded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> ((dec_mask & $past(v_tx_off)) == '0));

endmodule

// File: tb/fwd_filter_top_bench.sv
module fwd_filter_top_bench;

    localparam int N  = 3;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic          lk_ready;
    logic [PW-1:0] lk_ingress = '0;
    logic [N-1:0]  lk_dest = '0;
    logic          lk_bcast = 1'b0;
    logic [PW-1:0] sniffer_port = 2'd2;
    logic          dec_valid;
    logic [N-1:0]  dec_mask;
    logic          dec_drop, dec_learn;
    logic          reg_we = 1'b0;
    logic          reg_sel = 1'b0;
    logic [PW-1:0] reg_port = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [N-1:0]  st_link = 3'b101;
    logic [N-1:0]  st_duplex = 3'b011;
    logic [N-1:0]  st_speed = 3'b110;
    logic [N-1:0]  st_bist_fail = 3'b010;
    logic [N-1:0]  st_partner_fc = 3'b001;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fwd_filter_top #(.NPORTS(N)) u_fwd_filter_top (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_ingress(lk_ingress),
        .lk_dest(lk_dest), .lk_bcast(lk_bcast), .sniffer_port(sniffer_port),
        .dec_valid(dec_valid), .dec_mask(dec_mask), .dec_drop(dec_drop),
        .dec_learn(dec_learn),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_port(reg_port),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .st_link(st_link), .st_duplex(st_duplex), .st_speed(st_speed),
        .st_bist_fail(st_bist_fail), .st_partner_fc(st_partner_fc)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int port, input int sel, input int data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel[0]; reg_port = PW'(port); reg_wdata = data[7:0];
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic rd_check(input string req, input int port, input int sel, input int exp);
        reg_port = PW'(port); reg_sel = sel[0];
        #1;
        check(req, int'(reg_rdata), exp);
        reg_sel = 1'b0;
    endtask

    task automatic clear_ctrl();
        for (int p = 0; p < N; p++) wr(p, 0, 0);
    endtask

    task automatic lookup(input string req, input int ing, input int dest, input int bm,
                          input int snf, input int exp_mask, input int exp_drop,
                          input int exp_learn);
        @(negedge clk);
        lk_valid = 1'b1; lk_ingress = PW'(ing); lk_dest = N'(dest);
        lk_bcast = bm[0]; sniffer_port = PW'(snf);
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " valid"}, int'(dec_valid), 1);
        check({req, " mask"},  int'(dec_mask), exp_mask);
        check({req, " drop"},  int'(dec_drop), exp_drop);
        check({req, " learn"}, int'(dec_learn), exp_learn);
    endtask

    task automatic t_reset();
        check("R1 ready", int'(lk_ready), 1);
        check("R1 valid", int'(dec_valid), 0);
        for (int p = 0; p < N; p++) rd_check("R1 ctrl zero", p, 0, 0);
    endtask

    task automatic t_regs();
        wr(1, 0, 8'hA5);
        rd_check("R2 readback", 1, 0, 8'hA5);
        rd_check("R2 neighbour", 0, 0, 0);
        clear_ctrl();
        rd_check("R3 status p0", 0, 1, 8'h23);
        rd_check("R3 status p1", 1, 1, 8'h16);
        rd_check("R3 status p2", 2, 1, 8'h05);
        wr(1, 1, 8'hFF);
        rd_check("R3 status write ignored ctrl", 1, 0, 0);
        rd_check("R3 status write ignored stat", 1, 1, 8'h16);
    endtask

    task automatic t_handshake();
        lookup("R4 basic", 0, 3'b010, 0, 2, 3'b010, 0, 1);
        @(negedge clk);
        check("R4 one cycle", int'(dec_valid), 0);
    endtask

    task automatic t_loop();
        lookup("R5 self removed", 0, 3'b011, 0, 2, 3'b010, 0, 1);
        wr(0, 0, 8'h80);
        lookup("R5 loopback", 0, 3'b010, 0, 2, 3'b011, 0, 1);
        clear_ctrl();
    endtask

    task automatic t_rx_mirror();
        wr(0, 0, 8'h20);
        lookup("R6 rx mirror", 0, 3'b010, 0, 2, 3'b110, 0, 1);
        lookup("R6 rx mirror bcast", 0, 3'b010, 1, 2, 3'b110, 0, 1);
        wr(0, 0, 8'h30);
        lookup("R7 skip bcast", 0, 3'b010, 1, 2, 3'b010, 0, 1);
        lookup("R7 unicast kept", 0, 3'b010, 0, 2, 3'b110, 0, 1);
        clear_ctrl();
    endtask

    task automatic t_tx_mirror();
        wr(1, 0, 8'h40);
        lookup("R8 tx mirror", 0, 3'b010, 0, 2, 3'b110, 0, 1);
        lookup("R8 not a dest", 0, 3'b100, 0, 2, 3'b100, 0, 1);
        clear_ctrl();
    endtask

    task automatic t_tx_off();
        wr(2, 0, 8'h04);
        wr(0, 0, 8'h20);
        lookup("R9 sniffer off", 0, 3'b110, 0, 2, 3'b010, 0, 1);
        clear_ctrl();
        wr(1, 0, 8'h44);
        lookup("R9 dest off no mirror", 0, 3'b010, 0, 2, 3'b000, 0, 1);
        clear_ctrl();
        wr(0, 0, 8'h84);
        lookup("R9 loop target off", 0, 3'b010, 0, 2, 3'b010, 0, 1);
        clear_ctrl();
    endtask

    task automatic t_rx_off();
        wr(0, 0, 8'h02);
        lookup("R10 drop", 0, 3'b110, 0, 2, 3'b000, 1, 0);
        wr(0, 0, 8'hE2);
        lookup("R10 overrides", 0, 3'b110, 0, 2, 3'b000, 1, 0);
        clear_ctrl();
    endtask

    task automatic t_learn();
        wr(0, 0, 8'h01);
        lookup("R11 learn off", 0, 3'b010, 0, 2, 3'b010, 0, 0);
        wr(0, 0, 8'h00);
        lookup("R11 learn on", 0, 3'b010, 0, 2, 3'b010, 0, 1);
    endtask

    task automatic t_bad_sniffer();
        wr(0, 0, 8'h20);
        lookup("R12 no sniffer", 0, 3'b010, 0, 3, 3'b010, 0, 1);
        clear_ctrl();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_handshake();
        t_loop();
        t_rx_mirror();
        t_tx_mirror();
        t_tx_off();
        t_rx_off();
        t_learn();
        t_bad_sniffer();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule